// File: doc/BRIEF.md
# Local Bus Address and Chip-Select Decoder

This block sits between a host bus target and an 8-bit local peripheral bus. For each access it takes the offset of the access within the window the host has allocated and produces the local address lines and one of four active-low chip selects. Up to four external peripheral chips can then share the bus with no extra decoding logic.

Two kinds of access are decoded. An I/O access uses a byte-aligned window whose size can be set from 4 to 256 bytes. The offset bits inside that window reach the local address one for one, and the bits above it are cleared. A programmable decode bit position picks two adjacent offset bits that choose the chip select. Moving that position splits the window into four regions, two regions, or a single region. A memory access uses a fixed 4 KB DWORD-aligned window. It ignores both configuration fields, drives offset bits [9:2] onto the local address, and takes the chip select from offset bits [11:10]. Both outputs are registered.

Top module: `lb_csdec`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cs_n` becomes 4'b1111 and `la` becomes 0 after that edge.
- R2: A clock edge with `acc_stb` low drives `cs_n` to 4'b1111 and leaves `la` unchanged.
- R3: On an I/O access (`acc_stb`=1, `mem_sel`=0), the window size is 2^(`win_log2`+2) bytes, with code 7 treated as 6 (256 bytes). Each `la` bit below log2 of the size equals the same `ofs` bit, and every `la` bit at or above it is 0.
- R4: On an I/O access, bit i of `cs_n` (which drives CSi) is low for i = ((masked offset) >> p) mod 4, where p is the decode position. Every other bit is high.
- R5: With a 32-byte window (`win_log2`=3) and `dec_pos`=3, offsets 00-07h select CS0, 08-0Fh select CS1, 10-17h select CS2 and 18-1Fh select CS3.
- R6: With a 32-byte window and `dec_pos`=4, offsets 00-0Fh select CS0 and 10-1Fh select CS1. CS2 and CS3 are never selected.
- R7: When p is at or above log2 of the window size, every I/O offset selects CS0. A `dec_pos` value above 8 is treated as 8.
- R8: On a memory access (`acc_stb`=1, `mem_sel`=1), `la` equals `ofs[9:2]` and CSi is selected for i = `ofs[11:10]`, whatever the values of `win_log2` and `dec_pos`.
- R9: Both outputs update on the edge where the strobe is sampled, and exactly one `cs_n` bit is low after an edge that samples `acc_stb` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_stb | input | 1 | Access strobe, sampled each edge |
| mem_sel | input | 1 | 1 = memory access, 0 = I/O access |
| ofs | input | 12 | Offset of the access within the window |
| win_log2 | input | 3 | I/O window size code: size = 2^(code+2) bytes |
| dec_pos | input | 4 | Offset bit position of the low chip-select field (I/O only) |
| la | output | 8 | Registered local address |
| cs_n | output | 4 | Registered active-low chip selects, bit i drives CSi |

## Verification
Directed accesses walk the 32-byte window across the region boundaries for decode positions 3, 4 and 5. This separates a four-way split from a two-way split and from a single region. Offsets with set bits above the window, a window code of 7 and a decode position of 15 show whether masking takes place before decoding and whether both configuration fields are clamped. Memory accesses are issued with changing window and decode settings to confirm that those settings are ignored. Idle cycles between accesses show the chip selects releasing and the address holding. Several thousand seeded random accesses of both kinds, compared against bench reference functions, cover every window size and decode position.

// File: rtl/lb_csdec.sv
module lb_csdec #(
  parameter int LA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              mem_sel,
  input  logic [LA_W+3:0]   ofs,
  input  logic [2:0]        win_log2,
  input  logic [3:0]        dec_pos,
  output logic [LA_W-1:0]   la,
  output logic [3:0]        cs_n
);
  localparam int OFS_W   = LA_W + 4;
  localparam int EXT_W   = LA_W + 2;
  localparam int MAX_LOG = LA_W - 2;
  localparam int MAX_POS = LA_W;

  logic [2:0]       wl_c;
  logic [3:0]       pos_c;
  logic [LA_W:0]    span;
  logic [LA_W-1:0]  io_mask;
  logic [LA_W-1:0]  io_addr;
  logic [EXT_W-1:0] io_ext;
  logic [EXT_W-1:0] io_shift;
  logic [1:0]       sel;
  logic [LA_W-1:0]  nxt_la;

  assign wl_c    = (int'(win_log2) > MAX_LOG) ? 3'(MAX_LOG) : win_log2;
  assign pos_c   = (int'(dec_pos) > MAX_POS) ? 4'(MAX_POS) : dec_pos;
  assign span    = (LA_W+1)'(1) << ({1'b0, wl_c} + 4'd2);
  assign io_mask = LA_W'(span - (LA_W+1)'(1));
  assign io_addr = ofs[LA_W-1:0] & io_mask;
  assign io_ext  = {2'b00, io_addr};
  assign io_shift = io_ext >> pos_c;

  assign sel    = mem_sel ? ofs[OFS_W-1:OFS_W-2] : io_shift[1:0];
  assign nxt_la = mem_sel ? ofs[LA_W+1:2] : io_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la   <= '0;
      cs_n <= 4'b1111;
    end else if (acc_stb) begin
      la   <= nxt_la;
      cs_n <= ~(4'b0001 << sel);
    end else begin
      cs_n <= 4'b1111;
    end
  end

  assert_one_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> ($countones(~cs_n) == 1));

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |=> (cs_n == 4'b1111 && $stable(la)));

  assert_io_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !mem_sel) |=> ((la & ~$past(io_mask)) == '0));

  assert_single_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !mem_sel && ({1'b0, pos_c} >= ({2'b00, wl_c} + 5'd2)))
      |=> (cs_n == 4'b1110));

  assert_mem_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && mem_sel) |=> (la == $past(ofs[LA_W+1:2]) && !cs_n[$past(ofs[OFS_W-1:OFS_W-2])]));

  assert_cs_onehot0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

endmodule

// File: tb/lb_csdec_bench.sv
module lb_csdec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_stb;
  logic        mem_sel;
  logic [11:0] ofs;
  logic [2:0]  win_log2;
  logic [3:0]  dec_pos;
  logic [7:0]  la;
  logic [3:0]  cs_n;

  int errors = 0;
  int checks = 0;
  logic [7:0] hold_la;

  always #(CLK_PERIOD/2) clk = ~clk;

  lb_csdec u_lb_csdec (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .mem_sel(mem_sel),
    .ofs(ofs), .win_log2(win_log2), .dec_pos(dec_pos), .la(la), .cs_n(cs_n)
  );

  function automatic logic [7:0] ref_la(input logic m, input logic [11:0] o, input logic [2:0] w);
    int size;
    if (m) return 8'(int'(o) / 4);
    size = 4 << ((int'(w) > 6) ? 6 : int'(w));
    return 8'(int'(o) % size);
  endfunction

  function automatic logic [3:0] ref_cs(input logic m, input logic [11:0] o,
                                        input logic [2:0] w, input logic [3:0] d);
    int idx, p;
    if (m) idx = int'(o) / 1024;
    else begin
      p = (int'(d) > 8) ? 8 : int'(d);
      idx = (int'(ref_la(1'b0, o, w)) / (1 << p)) % 4;
    end
    return 4'hF ^ (4'h1 << idx);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic m, input logic [11:0] o, input logic [2:0] w,
                        input logic [3:0] d, input string req);
    logic [7:0] el;
    logic [3:0] ec;
    @(negedge clk);
    acc_stb = 1'b1; mem_sel = m; ofs = o; win_log2 = w; dec_pos = d;
    el = ref_la(m, o, w);
    ec = ref_cs(m, o, w, d);
    @(negedge clk);
    acc_stb = 1'b0;
    check(req, "la", int'(la), int'(el));
    check(req, "cs_n", int'(cs_n), int'(ec));
    hold_la = el;
  endtask

  task automatic idle(input logic [11:0] o, input string req);
    @(negedge clk);
    acc_stb = 1'b0; ofs = o; mem_sel = o[0];
    @(negedge clk);
    check(req, "idle cs_n", int'(cs_n), 32'hF);
    check(req, "idle la hold", int'(la), int'(hold_la));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; acc_stb = 1'b1; mem_sel = 1'b0; ofs = 12'hFFF; win_log2 = 3'd6; dec_pos = 4'd0;
    repeat (3) @(negedge clk);
    check("R1", "reset cs_n", int'(cs_n), 32'hF);
    check("R1", "reset la", int'(la), 0);
    acc_stb = 1'b0;
    rst_n = 1'b1;
    hold_la = 8'h00;

    for (int i = 0; i < 32; i++) access(1'b0, 12'(i), 3'd3, 4'd3, "R5");
    for (int i = 0; i < 32; i++) access(1'b0, 12'(i), 3'd3, 4'd4, "R6");
    for (int i = 0; i < 32; i++) access(1'b0, 12'(i), 3'd3, 4'd5, "R7");
    access(1'b0, 12'hEFF, 3'd3, 4'd3, "R3");
    access(1'b0, 12'h0FF, 3'd7, 4'd6, "R3");
    access(1'b0, 12'h0C3, 3'd0, 4'd0, "R3");
    access(1'b0, 12'h0FF, 3'd6, 4'd15, "R7");
    access(1'b0, 12'h0FF, 3'd6, 4'd7, "R4");
    access(1'b0, 12'h0BF, 3'd6, 4'd6, "R4");
    idle(12'h3A5, "R2");
    access(1'b1, 12'hFFC, 3'd0, 4'd0, "R8");
    access(1'b1, 12'h404, 3'd6, 4'd15, "R8");
    access(1'b1, 12'h8A8, 3'd2, 4'd3, "R8");
    access(1'b1, 12'h3FF, 3'd1, 4'd1, "R8");
    idle(12'h000, "R2");
    access(1'b0, 12'h018, 3'd3, 4'd3, "R9");
    access(1'b1, 12'hC00, 3'd3, 4'd3, "R9");

    for (int n = 0; n < 3000; n++) begin
      logic [11:0] o;
      logic [2:0]  w;
      logic [3:0]  d;
      o = 12'($urandom);
      w = 3'($urandom);
      d = 4'($urandom);
      if ($urandom % 7 == 0) idle(o, "R2");
      else access(1'($urandom), o, w, d, "R4");
    end

    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "re-reset cs_n", int'(cs_n), 32'hF);
    check("R1", "re-reset la", int'(la), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule